// File: doc/BRIEF.md
# Fractional Multiply-Accumulate ALU for Audio Effects

This block is the arithmetic core of a small audio effects processor. Each cycle the sequencer presents a 4-bit opcode and three 32-bit two's-complement operands, called A, X and Y. One clock later the block returns a 32-bit result and a condition flag word. The operations are:

- fractional (Q31) and integer multiply-accumulate, each with a fixed overflow policy of either saturating or wrapping;
- a three-input add;
- a bitwise mask-and-toggle;
- three signed compare-select forms;
- a linear interpolation step;
- a move that only feeds a private 64-bit accumulator.

Products are formed at full precision before any shift, and sums are formed wide before they are clamped or wrapped. The two format-conversion opcodes are not built here and return A unchanged. The conditional-skip opcode is only recognised: it raises a strobe for the sequencer to act on.

A result is produced only for a cycle with the input valid strobe high. The result, flags and skip strobe then hold until the next valid cycle. The accumulator is brought out on a port so the sequencer can read it.

Top module: `fxalu_core`

## Requirements
- R1: While reset is high and after it, until the first valid input, the result, flags, skip strobe, accumulator and output valid all read zero.
- R2: Opcode 0 returns A + ((X*Y) >>> 31), clamped to 0x7FFFFFFF / 0x80000000. Opcode 2 returns the same sum reduced modulo 2^32. `>>>` is an arithmetic shift of the exact 64-bit signed product.
- R3: Opcode 1 returns A + ((-(X*Y)) >>> 31), clamped. Opcode 3 returns the same sum reduced modulo 2^32. The product is negated before the shift.
- R4: Opcode 4 returns A + X*Y (exact integer product), clamped. Opcode 5 takes the low 31 bits of that exact sum and sign-extends bit 30 into bit 31.
- R5: Opcode 6 returns A + X + Y, clamped.
- R6: Opcode 7 returns A and adds ((X*Y) >>> 31) into the 64-bit accumulator, modulo 2^64. Every other opcode leaves the accumulator unchanged.
- R7: Opcode 8 returns (A AND X) XOR Y.
- R8: The compare-select opcodes use a signed comparison of A with Y. Opcode 9 returns X if A >= Y, otherwise NOT X. Opcode 10 returns X if A >= Y, otherwise Y. Opcode 11 returns X if A < Y, otherwise Y.
- R9: Opcode 14 returns A + ((X*(Y-A)) >>> 31), clamped. Y-A is formed exactly in 33 bits.
- R10: Opcodes 12, 13 and 15 return A. The skip strobe is 1 for a result from opcode 15 and 0 for a result from any other opcode.
- R11: Flag bits describe the result R. Bit 3 is 1 when R is zero. Bit 8 is 1 when R is nonzero. Bit 2 equals R[31]. Bit 0 is R[31] XOR R[30]. Bit 1 is 1 when A < Y compared as unsigned numbers. Bits 5 to 7 are 0.
- R12: Flag bit 4 is 1 only when a clamping opcode (0, 1, 4, 6 or 14) actually clamped its result. Wrapping opcodes and non-arithmetic opcodes never set it.
- R13: Outputs register on the clock edge that samples a valid input, so they are visible one cycle later. Output valid copies input valid with one cycle of delay. Cycles with input valid low change neither the outputs nor the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Operands and opcode are valid this cycle |
| opcode_i | input | 4 | Operation select |
| a_i | input | DW (32) | Operand A |
| x_i | input | DW (32) | Operand X |
| y_i | input | DW (32) | Operand Y |
| out_valid_o | output | 1 | Result registered from a valid input |
| result_o | output | DW (32) | Result R |
| flags_o | output | 9 | Condition flags |
| skip_o | output | 1 | Result came from the skip opcode |
| accum_o | output | 2*DW (64) | Internal accumulator |

## Verification
The bench builds the block with its default width of 32 bits, so the Q31 binary point sits at bit 31. That width puts the exact-precision corners within reach: full-scale negative times full-scale negative, whose shifted product is 2^31 and overflows a 32-bit sum, and an interpolation span Y-A that needs 33 bits. The same width lets the 31-bit wrap of opcode 5 and clamping in both directions be hit with directed operands. A long random run over all sixteen opcodes then compares every output and the accumulator against a wide behavioural model on every clock.

// File: rtl/fxalu_pkg.sv
package fxalu_pkg;

  typedef enum logic [3:0] {
    OP_FMAC_SAT = 4'd0,
    OP_FMSC_SAT = 4'd1,
    OP_FMAC_WRP = 4'd2,
    OP_FMSC_WRP = 4'd3,
    OP_IMAC_SAT = 4'd4,
    OP_IMAC_W31 = 4'd5,
    OP_ADD3_SAT = 4'd6,
    OP_ACC_MAC  = 4'd7,
    OP_ANDXOR   = 4'd8,
    OP_SIGNSEL  = 4'd9,
    OP_SEL_GE   = 4'd10,
    OP_SEL_LT   = 4'd11,
    OP_TOLOG    = 4'd12,
    OP_TOEXP    = 4'd13,
    OP_INTERP   = 4'd14,
    OP_SKIP     = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    OVF_SAT,
    OVF_WRAP,
    OVF_WRAP31
  } ovf_mode_e;

  localparam int FLAG_W      = 9;
  localparam int FLG_NORM    = 0;
  localparam int FLG_BORROW  = 1;
  localparam int FLG_MINUS   = 2;
  localparam int FLG_ZERO    = 3;
  localparam int FLG_SAT     = 4;
  localparam int FLG_NONZERO = 8;

endpackage

// File: rtl/fxalu_mul.sv
module fxalu_mul
  import fxalu_pkg::*;
#(
  parameter int DW = 32,
  parameter int SW = 2 * DW + 4
) (
  input  alu_op_e                op_i,
  input  logic signed [DW-1:0]   a_i,
  input  logic signed [DW-1:0]   x_i,
  input  logic signed [DW-1:0]   y_i,
  output logic signed [SW-1:0]   prod_o,
  output logic signed [SW-1:0]   frac_o
);
  localparam int OW = DW + 1;
  localparam int MW = 2 * OW;
  localparam int FB = DW - 1;

  logic signed [OW-1:0] mcand;
  logic signed [OW-1:0] mplier;
  logic signed [MW-1:0] raw;
  logic signed [SW-1:0] ext;
  logic signed [SW-1:0] sgn_p;

  always_comb begin
    mcand = {x_i[DW-1], x_i};
    if (op_i == OP_INTERP) begin
      mplier = {y_i[DW-1], y_i} - {a_i[DW-1], a_i};
    end else begin
      mplier = {y_i[DW-1], y_i};
    end
    raw = mcand * mplier;
    ext = {{(SW-MW){raw[MW-1]}}, raw};
    if (op_i == OP_FMSC_SAT || op_i == OP_FMSC_WRP) begin
      sgn_p = -ext;
    end else begin
      sgn_p = ext;
    end
    prod_o = sgn_p;
    frac_o = sgn_p >>> FB;
  end

endmodule

// File: rtl/fxalu_sat.sv
module fxalu_sat
  import fxalu_pkg::*;
#(
  parameter int DW = 32,
  parameter int SW = 2 * DW + 4
) (
  input  logic signed [SW-1:0] wide_i,
  input  ovf_mode_e            mode_i,
  output logic [DW-1:0]        res_o,
  output logic                 clamp_o
);
  localparam logic signed [SW-1:0] MAXW = {{(SW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [SW-1:0] MINW = {{(SW-DW+1){1'b1}}, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] MAXN = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MINN = {1'b1, {(DW-1){1'b0}}};

  always_comb begin
    clamp_o = 1'b0;
    res_o   = wide_i[DW-1:0];
    unique case (mode_i)
      OVF_SAT: begin
        if (wide_i > MAXW) begin
          res_o   = MAXN;
          clamp_o = 1'b1;
        end else if (wide_i < MINW) begin
          res_o   = MINN;
          clamp_o = 1'b1;
        end
      end
      OVF_WRAP31: res_o = {wide_i[DW-2], wide_i[DW-2:0]};
      default:    res_o = wide_i[DW-1:0];
    endcase
  end

endmodule

// File: rtl/fxalu_logic.sv
module fxalu_logic
  import fxalu_pkg::*;
#(
  parameter int DW = 32
) (
  input  alu_op_e              op_i,
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] y_i,
  output logic [DW-1:0]        res_o
);
  logic a_ge_y;

  always_comb begin
    a_ge_y = (a_i >= y_i);
    unique case (op_i)
      OP_ANDXOR: res_o = (a_i & x_i) ^ y_i;
      OP_SIGNSEL: res_o = a_ge_y ? x_i : ~x_i;
      OP_SEL_GE:  res_o = a_ge_y ? x_i : y_i;
      OP_SEL_LT:  res_o = a_ge_y ? y_i : x_i;
      default:    res_o = a_i;
    endcase
  end

endmodule

// File: rtl/fxalu_flags.sv
module fxalu_flags
  import fxalu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0]     res_i,
  input  logic [DW-1:0]     a_i,
  input  logic [DW-1:0]     y_i,
  input  logic              clamp_i,
  output logic [FLAG_W-1:0] flags_o
);
  always_comb begin
    flags_o              = '0;
    flags_o[FLG_NORM]    = res_i[DW-1] ^ res_i[DW-2];
    flags_o[FLG_BORROW]  = (a_i < y_i);
    flags_o[FLG_MINUS]   = res_i[DW-1];
    flags_o[FLG_ZERO]    = (res_i == '0);
    flags_o[FLG_SAT]     = clamp_i;
    flags_o[FLG_NONZERO] = (res_i != '0);
  end

endmodule

// File: rtl/fxalu_core.sv
module fxalu_core
  import fxalu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid_i,
  input  logic [3:0]           opcode_i,
  input  logic [DW-1:0]        a_i,
  input  logic [DW-1:0]        x_i,
  input  logic [DW-1:0]        y_i,
  output logic                 out_valid_o,
  output logic [DW-1:0]        result_o,
  output logic [FLAG_W-1:0]    flags_o,
  output logic                 skip_o,
  output logic [2*DW-1:0]      accum_o
);
  localparam int AW = 2 * DW;
  localparam int SW = 2 * DW + 4;

  alu_op_e              op;
  logic signed [SW-1:0] prod;
  logic signed [SW-1:0] frac;
  logic signed [SW-1:0] wa, wx, wy;
  logic signed [SW-1:0] wide_sum;
  ovf_mode_e            mode;
  logic                 is_arith;
  logic [DW-1:0]        sat_res;
  logic                 sat_clamp;
  logic [DW-1:0]        log_res;
  logic [DW-1:0]        r_next;
  logic [FLAG_W-1:0]    f_next;

  assign op = alu_op_e'(opcode_i);
  assign wa = {{(SW-DW){a_i[DW-1]}}, a_i};
  assign wx = {{(SW-DW){x_i[DW-1]}}, x_i};
  assign wy = {{(SW-DW){y_i[DW-1]}}, y_i};

  fxalu_mul #(.DW(DW), .SW(SW)) mul_i (
    .op_i   (op),
    .a_i    (a_i),
    .x_i    (x_i),
    .y_i    (y_i),
    .prod_o (prod),
    .frac_o (frac)
  );

  always_comb begin
    is_arith = 1'b1;
    mode     = OVF_SAT;
    wide_sum = '0;
    unique case (op)
      OP_FMAC_SAT, OP_FMSC_SAT, OP_INTERP: wide_sum = wa + frac;
      OP_FMAC_WRP, OP_FMSC_WRP: begin
        wide_sum = wa + frac;
        mode     = OVF_WRAP;
      end
      OP_IMAC_SAT: wide_sum = wa + prod;
      OP_IMAC_W31: begin
        wide_sum = wa + prod;
        mode     = OVF_WRAP31;
      end
      OP_ADD3_SAT: wide_sum = wa + wx + wy;
      default: begin
        is_arith = 1'b0;
        mode     = OVF_WRAP;
      end
    endcase
  end

  fxalu_sat #(.DW(DW), .SW(SW)) sat_i (
    .wide_i  (wide_sum),
    .mode_i  (mode),
    .res_o   (sat_res),
    .clamp_o (sat_clamp)
  );

  fxalu_logic #(.DW(DW)) logic_i (
    .op_i  (op),
    .a_i   (a_i),
    .x_i   (x_i),
    .y_i   (y_i),
    .res_o (log_res)
  );

  assign r_next = is_arith ? sat_res : log_res;

  fxalu_flags #(.DW(DW)) flags_i (
    .res_i   (r_next),
    .a_i     (a_i),
    .y_i     (y_i),
    .clamp_i (is_arith & sat_clamp),
    .flags_o (f_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
      flags_o     <= '0;
      skip_o      <= 1'b0;
      accum_o     <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        result_o <= r_next;
        flags_o  <= f_next;
        skip_o   <= (op == OP_SKIP);
        if (op == OP_ACC_MAC) begin
          accum_o <= accum_o + frac[AW-1:0];
        end
      end
    end
  end

  // R6: the accumulator moves only on a valid accumulate opcode
  p_acc_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(in_valid_i && opcode_i == 4'd7) |=> $stable(accum_o));

  // R13: idle cycles hold the registered outputs
  p_idle_hold_r13: assert property (@(posedge clk) disable iff (rst)
    !in_valid_i |=> ($stable(result_o) && $stable(flags_o) && $stable(skip_o)));

  // R13: output valid follows input valid by one cycle
  p_valid_follow_r13: assert property (@(posedge clk) disable iff (rst)
    in_valid_i |=> out_valid_o);

  // R12: a set saturate flag means a full-scale result
  p_sat_fullscale_r12: assert property (@(posedge clk) disable iff (rst)
    flags_o[FLG_SAT] |-> (result_o == {1'b0, {(DW-1){1'b1}}} ||
                          result_o == {1'b1, {(DW-1){1'b0}}}));

  // R11: zero and nonzero flags are exclusive once a result exists
  p_zero_excl_r11: assert property (@(posedge clk) disable iff (rst)
    out_valid_o |-> (flags_o[FLG_ZERO] != flags_o[FLG_NONZERO]));

  // R10: the skip strobe only rises from a valid input
  p_skip_src_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(skip_o) |-> $past(in_valid_i));

endmodule

// File: tb/fxalu_core_tb.sv
`timescale 1ns/1ps
module fxalu_core_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  opcode = 4'd0;
  logic [31:0] a = '0, x = '0, y = '0;
  logic        out_valid;
  logic [31:0] result;
  logic [8:0]  flags;
  logic        skip;
  logic [63:0] accum;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [63:0] m_acc = '0;

  always #2.5 clk = ~clk;

  fxalu_core #(.DW(32)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .in_valid_i  (in_valid),
    .opcode_i    (opcode),
    .a_i         (a),
    .x_i         (x),
    .y_i         (y),
    .out_valid_o (out_valid),
    .result_o    (result),
    .flags_o     (flags),
    .skip_o      (skip),
    .accum_o     (accum)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string op_tag(input int op);
    case (op)
      0, 2: return "R2";
      1, 3: return "R3";
      4, 5: return "R4";
      6: return "R5";
      7: return "R6";
      8: return "R7";
      9, 10, 11: return "R8";
      14: return "R9";
      default: return "R10";
    endcase
  endfunction

  // Behavioural model: wide signed arithmetic straight from the requirements
  function automatic void model(input int op, input logic [31:0] ia, ix, iy,
                                inout logic [63:0] acc,
                                output logic [31:0] r, output logic [8:0] f,
                                output logic sk);
    logic signed [127:0] sa, sx, sy, p, w, t;
    logic sat_op, clamp;
    sa = {{96{ia[31]}}, ia};
    sx = {{96{ix[31]}}, ix};
    sy = {{96{iy[31]}}, iy};
    p = sx * sy;
    w = '0;
    sat_op = 1'b0;
    clamp = 1'b0;
    r = ia;
    case (op)
      0: begin w = sa + (p >>> 31); sat_op = 1'b1; end
      1: begin t = -p; w = sa + (t >>> 31); sat_op = 1'b1; end
      2: begin w = sa + (p >>> 31); r = w[31:0]; end
      3: begin t = -p; w = sa + (t >>> 31); r = w[31:0]; end
      4: begin w = sa + p; sat_op = 1'b1; end
      5: begin w = sa + p; r = {w[30], w[30:0]}; end
      6: begin w = sa + sx + sy; sat_op = 1'b1; end
      7: begin t = p >>> 31; acc = acc + t[63:0]; r = ia; end
      8: r = (ia & ix) ^ iy;
      9: r = ($signed(ia) >= $signed(iy)) ? ix : ~ix;
      10: r = ($signed(ia) >= $signed(iy)) ? ix : iy;
      11: r = ($signed(ia) < $signed(iy)) ? ix : iy;
      14: begin t = sx * (sy - sa); w = sa + (t >>> 31); sat_op = 1'b1; end
      default: r = ia;
    endcase
    if (sat_op) begin
      if (w > 128'sh7fffffff) begin r = 32'h7fffffff; clamp = 1'b1; end
      else if (w < -128'sh80000000) begin r = 32'h80000000; clamp = 1'b1; end
      else r = w[31:0];
    end
    f = '0;
    f[0] = r[31] ^ r[30];
    f[1] = (ia < iy);
    f[2] = r[31];
    f[3] = (r == 0);
    f[4] = clamp;
    f[8] = (r != 0);
    sk = (op == 15);
  endfunction

  task automatic apply(input int op, input logic [31:0] ia, ix, iy);
    logic [31:0] er;
    logic [8:0] ef;
    logic es;
    @(negedge clk);
    opcode = op[3:0]; a = ia; x = ix; y = iy; in_valid = 1'b1;
    model(op, ia, ix, iy, m_acc, er, ef, es);
    @(negedge clk);
    in_valid = 1'b0;
    check({op_tag(op), " result"}, {32'd0, result}, {32'd0, er});
    check("R11 flags", {55'd0, flags & 9'h1ef}, {55'd0, ef & 9'h1ef});
    check("R12 sat flag", {63'd0, flags[4]}, {63'd0, ef[4]});
    check("R10 skip", {63'd0, skip}, {63'd0, es});
    check("R6 accumulator", accum, m_acc);
    check("R13 out_valid", {63'd0, out_valid}, 64'd1);
  endtask

  task automatic idle_check(input logic [31:0] ia);
    logic [31:0] hr;
    logic [8:0] hf;
    logic [63:0] hacc;
    hr = result; hf = flags; hacc = accum;
    @(negedge clk);
    opcode = 4'd7; a = ia; x = 32'h7fffffff; y = 32'h7fffffff; in_valid = 1'b0;
    @(negedge clk);
    check("R13 idle result", {32'd0, result}, {32'd0, hr});
    check("R13 idle flags", {55'd0, flags}, {55'd0, hf});
    check("R13 idle valid", {63'd0, out_valid}, 64'd0);
    check("R6 idle accumulator", accum, hacc);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset result", {32'd0, result}, 64'd0);
    check("R1 reset flags", {55'd0, flags}, 64'd0);
    check("R1 reset acc", accum, 64'd0);
    check("R1 reset valid", {63'd0, out_valid}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 post-reset skip", {63'd0, skip}, 64'd0);
    check("R1 post-reset acc", accum, 64'd0);

    // R2: full-scale negative squared overflows; clamp versus wrap
    apply(0, 32'h00000000, 32'h80000000, 32'h80000000);
    apply(2, 32'h00000000, 32'h80000000, 32'h80000000);
    apply(0, 32'h10000000, 32'h40000000, 32'h20000000);
    // R3: negated product, rounding of negative shift, both policies
    apply(1, 32'h80000000, 32'h40000000, 32'h40000000);
    apply(3, 32'h80000000, 32'h40000000, 32'h40000000);
    apply(1, 32'h00000000, 32'h00000001, 32'h00000001);
    // R4: integer product clamp and 31-bit wrap
    apply(4, 32'h00000005, 32'h00010000, 32'h00010000);
    apply(5, 32'h00000005, 32'h00010000, 32'h00004000);
    apply(5, 32'h3fffffff, 32'h00000001, 32'h00000001);
    // R5: three-input add clamps negative
    apply(6, 32'h80000000, 32'hffffffff, 32'h00000000);
    apply(6, 32'h00000001, 32'h00000002, 32'h00000003);
    // R6: accumulator gathers several products
    apply(7, 32'h12345678, 32'h40000000, 32'h40000000);
    apply(7, 32'h00000000, 32'h80000000, 32'h80000000);
    apply(7, 32'h00000000, 32'h80000000, 32'h7fffffff);
    idle_check(32'hdeadbeef);
    // R7
    apply(8, 32'hf0f0f0f0, 32'h0ff00ff0, 32'h00ff00ff);
    // R8: equal, signed negative, and reversed operands
    apply(9, 32'h00000004, 32'h11111111, 32'h00000004);
    apply(9, 32'hfffffff0, 32'h11111111, 32'h00000004);
    apply(10, 32'h80000000, 32'h22222222, 32'h00000001);
    apply(10, 32'h00000001, 32'h22222222, 32'h80000000);
    apply(11, 32'h80000000, 32'h33333333, 32'h00000001);
    apply(11, 32'h00000007, 32'h33333333, 32'h00000007);
    // R9: span Y-A needs 33 bits
    apply(14, 32'h80000000, 32'h7fffffff, 32'h7fffffff);
    apply(14, 32'h7fffffff, 32'h7fffffff, 32'h80000000);
    apply(14, 32'h00001000, 32'h40000000, 32'h00003000);
    // R10
    apply(12, 32'hcafef00d, 32'h1, 32'h2);
    apply(13, 32'h00000000, 32'h1, 32'h2);
    apply(15, 32'h00000008, 32'h3, 32'h4);
    apply(8, 32'h0, 32'h0, 32'h0);
    idle_check(32'h0);

    for (int i = 0; i < 2000; i++) begin
      logic [31:0] ra, rx, ry;
      int sel;
      sel = $urandom_range(0, 3);
      ra = (sel == 0) ? 32'h80000000 : $urandom;
      rx = (sel == 1) ? 32'h7fffffff : $urandom;
      ry = (sel == 2) ? 32'h80000000 : $urandom;
      apply($urandom_range(0, 15), ra, rx, ry);
      if (i % 97 == 0) idle_check($urandom);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule